// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block handles the architectural side of taking and leaving an interrupt for four classes: base, critical, machine check and debug. When a request is accepted, the block stores the interrupted instruction address and the current status word in the save pair that belongs to the class. It captures the syndrome value, clears status bits according to the rules for that class, and issues a redirect to a vector address. The vector address joins a common prefix register with an offset register chosen per interrupt.

When the return strobe of a class fires, the block copies that class's saved status back into the live status word. It also redirects fetch to the saved address. The prefix and the offset registers are loaded only through a special-register write port and are not reset. A parameter selects whether debug has its own save pair. Without it, debug shares the critical pair and critical entries also clear the debug enable.

Top module: `irq_seq`

## Requirements
- R1: During and after reset, `stat_o` equals `STAT_RST` (default 0x001017FF), `synd_o` is 0 and `redirect_vld_o` is 0.
- R2: `take_o` is combinational and one-hot or zero. Class bits are 0 base, 1 critical, 2 machine check and 3 debug. Priority is machine check, then debug, then critical, then base. A class is accepted only while its enable bit in the status word is 1: bit 1 for base, bit 9 for critical, bit 10 for debug and bit 8 for machine check.
- R3: One edge after an acceptance, `redirect_vld_o` pulses for exactly one cycle. `redirect_pc_o` then equals the 48-bit prefix in address bits 63:16, the 12-bit offset selected by the class's `vec_idx_i` slice in bits 15:4, and zeros in bits 3:0.
- R4: Every entry clears status bits 7:0.
- R5: Status bit 8 is cleared by a machine check entry and kept by every other entry.
- R6: Status bit 9 is cleared by critical, debug and machine check entries and kept by base entries.
- R7: Status bit 10 is cleared by debug and machine check entries, and by critical entries only when `HAS_EDBG` is 0. It is kept otherwise.
- R8: On every entry, status bit 11 takes the old value of bit 12. All bits not named in R4 to R7 keep their values.
- R9: `synd_o` takes `synd_i` on each entry and holds its value otherwise.
- R10: One edge after a return strobe, `stat_o` holds the status word that was live just before that class's last entry. `redirect_pc_o` holds the `ret_pc_i` captured at that entry, and `redirect_vld_o` pulses.
- R11: With `HAS_EDBG` = 0, debug entries save into the critical pair, and the critical return strobe restores them.
- R12: Any asserted return strobe blocks acceptance in that cycle. A request still held is accepted in the following cycle.
- R13: A write with `spr_addr_i` bit 4 set loads the prefix from `spr_wdata_i` bits 59:12. Otherwise the write loads offset entry `spr_addr_i[3:0]` from bits 11:0. Write data carries address bits 63:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 4 | Level requests per class |
| vec_idx_i | input | 4x4 | Offset entry index per class |
| ret_pc_i | input | 64 | Address saved on entry |
| synd_i | input | 32 | Syndrome value loaded on entry |
| ret_i | input | 4 | Return strobes per class |
| spr_we_i | input | 1 | Vector register write enable |
| spr_addr_i | input | 5 | Bit 4 selects the prefix, bits 3:0 select the offset entry |
| spr_wdata_i | input | 60 | Write data, address bits 63:4 |
| take_o | output | 4 | Accepted class, one-hot |
| stat_o | output | 32 | Live status word |
| synd_o | output | 32 | Syndrome register |
| redirect_vld_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | 64 | Redirect target |

## Verification
`take_o` settles in the same cycle as the request or strobe that causes it. The bench therefore reads it 1 ns after driving, well before the next rising edge. Status, syndrome and the redirect pair are all due exactly one edge later, so each check samples 1 ns after that edge. A further check, one edge on, confirms that the redirect pulse has dropped. The R12 case holds the request across the strobe cycle and looks for acceptance only after the strobe has been removed.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int N_CLS  = 4;
  localparam int C_BASE = 0;
  localparam int C_CRIT = 1;
  localparam int C_MCHK = 2;
  localparam int C_DBG  = 3;

  // status bit positions
  localparam int B_WAIT  = 0;
  localparam int B_EXT   = 1;
  localparam int B_USR   = 2;
  localparam int B_FPU   = 3;
  localparam int B_FX0   = 4;
  localparam int B_FX1   = 5;
  localparam int B_IAS   = 6;
  localparam int B_DAS   = 7;
  localparam int B_MCK   = 8;
  localparam int B_CRT   = 9;
  localparam int B_DBG   = 10;
  localparam int B_WIDE  = 11;
  localparam int B_IWIDE = 12;
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_seq_pkg::*;
(
  input  logic [N_CLS-1:0] req_i,
  input  logic [N_CLS-1:0] en_i,
  input  logic             block_i,
  output logic [N_CLS-1:0] pick_o
);
  localparam int PRIO [N_CLS] = '{C_MCHK, C_DBG, C_CRIT, C_BASE};

  logic hit;

  always_comb begin
    pick_o = '0;
    hit    = 1'b0;
    for (int i = 0; i < N_CLS; i++) begin
      if (!hit && !block_i && req_i[PRIO[i]] && en_i[PRIO[i]]) begin
        pick_o[PRIO[i]] = 1'b1;
        hit             = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_stat_upd.sv
module irq_stat_upd
  import irq_seq_pkg::*;
#(
  parameter int STAT_W   = 32,
  parameter bit HAS_EDBG = 1'b1
) (
  input  logic [STAT_W-1:0] stat_i,
  input  logic [N_CLS-1:0]  cls_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] clr;

  always_comb begin
    clr          = '0;
    clr[B_WAIT]  = 1'b1;
    clr[B_EXT]   = 1'b1;
    clr[B_USR]   = 1'b1;
    clr[B_FPU]   = 1'b1;
    clr[B_FX0]   = 1'b1;
    clr[B_FX1]   = 1'b1;
    clr[B_IAS]   = 1'b1;
    clr[B_DAS]   = 1'b1;
    clr[B_MCK]   = cls_i[C_MCHK];
    clr[B_CRT]   = cls_i[C_CRIT] | cls_i[C_DBG] | cls_i[C_MCHK];
    clr[B_DBG]   = cls_i[C_DBG] | cls_i[C_MCHK] | (cls_i[C_CRIT] & !HAS_EDBG);
    stat_o         = stat_i & ~clr;
    stat_o[B_WIDE] = stat_i[B_IWIDE];
  end
endmodule

// File: rtl/irq_vtbl.sv
module irq_vtbl #(
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 12,
  parameter int ALN_W  = 4,
  parameter int N_VEC  = 16
) (
  input  logic                      clk_i,
  input  logic                      we_i,
  input  logic [$clog2(N_VEC):0]    addr_i,
  input  logic [ADDR_W-ALN_W-1:0]   wdata_i,
  input  logic [$clog2(N_VEC)-1:0]  idx_i,
  output logic [ADDR_W-1:0]         vec_o
);
  localparam int VIDX_W = $clog2(N_VEC);
  localparam int DAT_W  = ADDR_W - ALN_W;
  localparam int PFX_W  = DAT_W - OFF_W;

  logic [PFX_W-1:0] pfx_q;
  logic [OFF_W-1:0] off_q [N_VEC];

  // no reset: contents undefined until written
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      if (addr_i[VIDX_W]) pfx_q <= wdata_i[DAT_W-1:OFF_W];
      else                off_q[addr_i[VIDX_W-1:0]] <= wdata_i[OFF_W-1:0];
    end
  end

  assign vec_o = {pfx_q, off_q[idx_i], {ALN_W{1'b0}}};
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int                ADDR_W   = 64,
  parameter int                STAT_W   = 32,
  parameter int                SYND_W   = 32,
  parameter int                N_VEC    = 16,
  parameter int                OFF_W    = 12,
  parameter int                ALN_W    = 4,
  parameter bit                HAS_EDBG = 1'b1,
  parameter logic [STAT_W-1:0] STAT_RST = 32'h0010_17FF
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [N_CLS-1:0]                       req_i,
  input  logic [N_CLS-1:0][$clog2(N_VEC)-1:0]    vec_idx_i,
  input  logic [ADDR_W-1:0]                      ret_pc_i,
  input  logic [SYND_W-1:0]                      synd_i,
  input  logic [N_CLS-1:0]                       ret_i,
  input  logic                                   spr_we_i,
  input  logic [$clog2(N_VEC):0]                 spr_addr_i,
  input  logic [ADDR_W-ALN_W-1:0]                spr_wdata_i,
  output logic [N_CLS-1:0]                       take_o,
  output logic [STAT_W-1:0]                      stat_o,
  output logic [SYND_W-1:0]                      synd_o,
  output logic                                   redirect_vld_o,
  output logic [ADDR_W-1:0]                      redirect_pc_o
);
  localparam int VIDX_W = $clog2(N_VEC);
  localparam int N_PAIR = HAS_EDBG ? 4 : 3;

  logic [STAT_W-1:0] stat_q, stat_nxt;
  logic [SYND_W-1:0] synd_q;
  logic              vld_q;
  logic [ADDR_W-1:0] rpc_q, vec_pc;
  logic [N_CLS-1:0]  en, ret_oh;
  logic              take_any, ret_any;
  logic [1:0]        tcls, rcls, tpair, rpair;
  logic [ADDR_W-1:0] sv_pc_q   [N_PAIR];
  logic [STAT_W-1:0] sv_stat_q [N_PAIR];
  logic [ADDR_W-1:0] rd_pc;
  logic [STAT_W-1:0] rd_stat;

  function automatic logic [1:0] oh2idx(input logic [N_CLS-1:0] oh);
    oh2idx = '0;
    for (int i = 0; i < N_CLS; i++) if (oh[i]) oh2idx = 2'(i);
  endfunction

  // debug folds onto the critical pair without its own
  function automatic logic [1:0] pair_of(input logic [1:0] c);
    if (c == 2'(C_DBG) && !HAS_EDBG) return 2'(C_CRIT);
    return c;
  endfunction

  always_comb begin
    en         = '0;
    en[C_BASE] = stat_q[B_EXT];
    en[C_CRIT] = stat_q[B_CRT];
    en[C_MCHK] = stat_q[B_MCK];
    en[C_DBG]  = stat_q[B_DBG];
  end

  assign ret_any = |ret_i;

  irq_pick u_take (
    .req_i   (req_i),
    .en_i    (en),
    .block_i (ret_any),
    .pick_o  (take_o)
  );

  irq_pick u_ret (
    .req_i   (ret_i),
    .en_i    ({N_CLS{1'b1}}),
    .block_i (1'b0),
    .pick_o  (ret_oh)
  );

  assign take_any = |take_o;
  assign tcls     = oh2idx(take_o);
  assign rcls     = oh2idx(ret_oh);
  assign tpair    = pair_of(tcls);
  assign rpair    = pair_of(rcls);

  irq_stat_upd #(.STAT_W(STAT_W), .HAS_EDBG(HAS_EDBG)) u_upd (
    .stat_i (stat_q),
    .cls_i  (take_o),
    .stat_o (stat_nxt)
  );

  irq_vtbl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ALN_W(ALN_W), .N_VEC(N_VEC)) u_vtbl (
    .clk_i   (clk_i),
    .we_i    (spr_we_i),
    .addr_i  (spr_addr_i),
    .wdata_i (spr_wdata_i),
    .idx_i   (vec_idx_i[tcls]),
    .vec_o   (vec_pc)
  );

  always_comb begin
    rd_pc   = '0;
    rd_stat = '0;
    for (int p = 0; p < N_PAIR; p++) begin
      if (rpair == 2'(p)) begin
        rd_pc   = sv_pc_q[p];
        rd_stat = sv_stat_q[p];
      end
    end
  end

  // save uses the pre-entry status: copy happens before the update lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < N_PAIR; p++) begin
        sv_pc_q[p]   <= '0;
        sv_stat_q[p] <= '0;
      end
    end else if (take_any) begin
      for (int p = 0; p < N_PAIR; p++) begin
        if (tpair == 2'(p)) begin
          sv_pc_q[p]   <= ret_pc_i;
          sv_stat_q[p] <= stat_q;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= STAT_RST;
      synd_q <= '0;
      vld_q  <= 1'b0;
      rpc_q  <= '0;
    end else if (ret_any) begin
      stat_q <= rd_stat;
      rpc_q  <= rd_pc;
      vld_q  <= 1'b1;
    end else if (take_any) begin
      stat_q <= stat_nxt;
      synd_q <= synd_i;
      rpc_q  <= vec_pc;
      vld_q  <= 1'b1;
    end else begin
      vld_q  <= 1'b0;
    end
  end

  assign stat_o         = stat_q;
  assign synd_o         = synd_q;
  assign redirect_vld_o = vld_q;
  assign redirect_pc_o  = rpc_q;
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk
  import irq_seq_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_CLS-1:0]  take_o,
  input logic [N_CLS-1:0]  ret_i,
  input logic [STAT_W-1:0] stat_o,
  input logic              redirect_vld_o
);
  // R2
  take_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take_o));

  // R2
  base_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o[C_BASE] |-> stat_o[B_EXT]);

  // R12
  ret_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ret_i) |-> (take_o == '0));

  // R3
  redir_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|take_o) |=> redirect_vld_o);

  // R4
  low_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|take_o) |=> (stat_o[B_DAS:B_WAIT] == '0));

  // R5
  mck_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|take_o) && !take_o[C_MCHK]) |=> (stat_o[B_MCK] == $past(stat_o[B_MCK])));

  // R6
  crt_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o[C_BASE] |=> (stat_o[B_CRT] == $past(stat_o[B_CRT])));

  // R8
  wide_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|take_o) |=> (stat_o[B_WIDE] == $past(stat_o[B_IWIDE])));
endmodule

bind irq_seq irq_seq_chk #(.STAT_W(STAT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .take_o         (take_o),
  .ret_i          (ret_i),
  .stat_o         (stat_o),
  .redirect_vld_o (redirect_vld_o)
);

// File: tb/tb_irq_seq.sv
module tb_irq_seq;
  localparam logic [31:0] S0   = 32'h0010_17FF;
  localparam logic [47:0] PFX  = 48'h1234_5678_9ABC;
  localparam int          BASE = 0, CRIT = 1, MCHK = 2, DBG = 3;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [3:0]       req = '0, ret = '0, req2 = '0, ret2 = '0;
  logic [3:0][3:0]  vidx;
  logic [63:0]      ret_pc = '0;
  logic [31:0]      synd = '0;
  logic             spr_we = 1'b0;
  logic [4:0]       spr_addr = '0;
  logic [59:0]      spr_wdata = '0;
  logic [3:0]       take_o, take2_o;
  logic [31:0]      stat_o, stat2_o, synd_o, synd2_o;
  logic             vld_o, vld2_o;
  logic [63:0]      rpc_o, rpc2_o;
  int               n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  assign vidx = {4'd14, 4'd9, 4'd5, 4'd3};

  irq_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .vec_idx_i(vidx), .ret_pc_i(ret_pc),
    .synd_i(synd), .ret_i(ret), .spr_we_i(spr_we), .spr_addr_i(spr_addr),
    .spr_wdata_i(spr_wdata), .take_o(take_o), .stat_o(stat_o), .synd_o(synd_o),
    .redirect_vld_o(vld_o), .redirect_pc_o(rpc_o)
  );

  irq_seq #(.HAS_EDBG(1'b0)) dut_nd (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req2), .vec_idx_i(vidx), .ret_pc_i(ret_pc),
    .synd_i(synd), .ret_i(ret2), .spr_we_i(spr_we), .spr_addr_i(spr_addr),
    .spr_wdata_i(spr_wdata), .take_o(take2_o), .stat_o(stat2_o), .synd_o(synd2_o),
    .redirect_vld_o(vld2_o), .redirect_pc_o(rpc2_o)
  );

  function automatic logic [11:0] off_of(input int k);
    return 12'h040 + 12'(k) * 12'h031;
  endfunction

  function automatic logic [63:0] vec_of(input int k);
    return {PFX, off_of(k), 4'h0};
  endfunction

  // expected status after entry, from the clearing rules
  function automatic logic [31:0] exp_entry(input logic [31:0] s, input int c, input bit edbg);
    logic [31:0] r;
    r = s & ~32'hFF;
    if (c == MCHK) r[8] = 1'b0;
    if (c != BASE) r[9] = 1'b0;
    if (c == DBG || c == MCHK || (c == CRIT && !edbg)) r[10] = 1'b0;
    r[11] = s[12];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic enter(input logic [3:0] rq, input logic [63:0] pc, input logic [31:0] sy,
                       output logic [3:0] tk);
    @(negedge clk);
    req = rq; ret_pc = pc; synd = sy;
    #1 tk = take_o;
    @(posedge clk);
    #1 req = '0;
  endtask

  task automatic leave(input logic [3:0] rt);
    @(negedge clk);
    ret = rt;
    @(posedge clk);
    #1 ret = '0;
  endtask

  task automatic t_reset;
    chk("R1 stat", 64'(stat_o), 64'(S0));
    chk("R1 synd", 64'(synd_o), 64'h0);
    chk("R1 vld", 64'(vld_o), 64'h0);
  endtask

  task automatic t_spr;
    @(negedge clk);
    spr_we = 1'b1; spr_addr = 5'h10; spr_wdata = {PFX, 12'h000};
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      spr_addr = 5'(k); spr_wdata = {48'hFFFF_FFFF_FFFF, off_of(k)};
    end
    @(negedge clk);
    spr_we = 1'b0;
  endtask

  task automatic t_base;
    logic [3:0] tk;
    enter(4'b0001, 64'hA000_0000_0000_1000, 32'h0000_B001, tk);
    chk("R2 base take", 64'(tk), 64'h1);
    chk("R3 vld", 64'(vld_o), 64'h1);
    chk("R3 R13 base vector", rpc_o, vec_of(3));
    chk("R4 R8 base stat", 64'(stat_o), 64'(exp_entry(S0, BASE, 1)));
    chk("R9 synd", 64'(synd_o), 64'h0000_B001);
    @(posedge clk); #1;
    chk("R3 vld drop", 64'(vld_o), 64'h0);
    leave(4'b0001);
    chk("R10 base ret pc", rpc_o, 64'hA000_0000_0000_1000);
    chk("R10 base ret stat", 64'(stat_o), 64'(S0));
    chk("R10 ret vld", 64'(vld_o), 64'h1);
  endtask

  task automatic t_prio;
    logic [3:0] tk;
    enter(4'b1111, 64'hA000_0000_0000_2000, 32'h0000_C002, tk);
    chk("R2 mchk wins", 64'(tk), 64'h4);
    chk("R3 mchk vector", rpc_o, vec_of(9));
    chk("R5 R6 R7 mchk stat", 64'(stat_o), 64'(exp_entry(S0, MCHK, 1)));
    enter(4'b0001, 64'hA000_0000_0000_2100, 32'h0000_DEAD, tk);
    chk("R2 base gated", 64'(tk), 64'h0);
    chk("R2 gated no vld", 64'(vld_o), 64'h0);
    chk("R9 synd held", 64'(synd_o), 64'h0000_C002);
    leave(4'b0100);
    chk("R10 mchk ret pc", rpc_o, 64'hA000_0000_0000_2000);
    chk("R10 mchk ret stat", 64'(stat_o), 64'(S0));
  endtask

  task automatic t_crit;
    logic [3:0] tk;
    enter(4'b0011, 64'hA000_0000_0000_3000, 32'h0000_C003, tk);
    chk("R2 crit over base", 64'(tk), 64'h2);
    chk("R3 crit vector", rpc_o, vec_of(5));
    chk("R5 R6 R7 crit stat", 64'(stat_o), 64'(exp_entry(S0, CRIT, 1)));
    leave(4'b0010);
    chk("R10 crit ret pc", rpc_o, 64'hA000_0000_0000_3000);
    chk("R10 crit ret stat", 64'(stat_o), 64'(S0));
  endtask

  task automatic t_dbg;
    logic [3:0] tk;
    enter(4'b1011, 64'hA000_0000_0000_4000, 32'h0000_C004, tk);
    chk("R2 dbg over crit", 64'(tk), 64'h8);
    chk("R3 dbg vector", rpc_o, vec_of(14));
    chk("R5 R6 R7 dbg stat", 64'(stat_o), 64'(exp_entry(S0, DBG, 1)));
    leave(4'b1000);
    chk("R10 dbg ret pc", rpc_o, 64'hA000_0000_0000_4000);
    chk("R10 dbg ret stat", 64'(stat_o), 64'(S0));
  endtask

  task automatic t_ret_prio;
    @(negedge clk);
    req = 4'b0001; ret = 4'b0010; ret_pc = 64'hA000_0000_0000_5000;
    #1 chk("R12 blocked", 64'(take_o), 64'h0);
    @(posedge clk); #1;
    ret = '0;
    chk("R12 ret pc", rpc_o, 64'hA000_0000_0000_3000);
    chk("R12 ret stat", 64'(stat_o), 64'(S0));
    #1 chk("R12 pending taken", 64'(take_o), 64'h1);
    @(posedge clk); #1;
    req = '0;
    chk("R12 late vector", rpc_o, vec_of(3));
    leave(4'b0001);
    chk("R12 late ret pc", rpc_o, 64'hA000_0000_0000_5000);
  endtask

  task automatic t_nd;
    @(negedge clk);
    req2 = 4'b1000; ret_pc = 64'hA000_0000_0000_6000;
    #1 chk("R11 nd dbg take", 64'(take2_o), 64'h8);
    @(posedge clk); #1;
    req2 = '0;
    chk("R11 nd dbg stat", 64'(stat2_o), 64'(exp_entry(S0, DBG, 0)));
    @(negedge clk);
    ret2 = 4'b0010;
    @(posedge clk); #1;
    ret2 = '0;
    chk("R11 shared pair pc", rpc2_o, 64'hA000_0000_0000_6000);
    chk("R11 shared pair stat", 64'(stat2_o), 64'(S0));
    @(negedge clk);
    req2 = 4'b0010; ret_pc = 64'hA000_0000_0000_7000;
    @(posedge clk); #1;
    req2 = '0;
    chk("R7 nd crit clears dbg en", 64'(stat2_o), 64'(exp_entry(S0, CRIT, 0)));
    @(negedge clk);
    ret2 = 4'b0010;
    @(posedge clk); #1;
    ret2 = '0;
    chk("R11 nd crit ret pc", rpc2_o, 64'hA000_0000_0000_7000);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_spr();
    t_base();
    t_prio();
    t_crit();
    t_dbg();
    t_ret_prio();
    t_nd();
    repeat (2) @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule